// File: doc/BRIEF.md
# Link Training Rate Fallback Controller

This block brings a serial display link up before any picture data is allowed through. When the hot-plug input goes high it takes the sink's advertised top rate and lane count, asks the transmitter for a clock-recovery training pattern, then for an alignment pattern. It raises the transmitter equalization setting by one on every attempt that does not lock. Only when every active lane reports both clock lock and symbol/equalization lock does it raise `link_up`, which the surrounding logic uses as the gate for video.

If a phase runs out of attempts, the controller steps one rung down a fixed rate ladder. Rate codes 0, 1, 2 and 3 stand for 1.62, 2.7, 5.4 and 8.1 Gb/s per lane. Once the lowest rung has failed, it halves the lane count and climbs back to the top allowed rate. A failure at a single lane and the lowest rate parks the block in an error state. Losing lock on a running link first retrains at the same settings. Dropping hot-plug returns it to idle from anywhere.

States: `LT_IDLE` (waiting), `LT_CLKREC` (clock-recovery phase), `LT_ALIGN` (symbol/equalization phase), `LT_LIVE` (link ready), `LT_HALT` (error). Transitions:
- start: idle to clock-recovery.
- cr_pass: clock-recovery to align.
- eq_pass: align to live.
- retry: stay in a phase with the next equalization level.
- fallback: from either phase back to clock-recovery at the next ladder point.
- exhaust: from either phase to halt.
- relock: live to clock-recovery.
- unplug: any state to idle.

Top module: `link_train_ctrl`

## Requirements
- R1: After reset the outputs are `link_up`=0, `train_err`=0, `pattern_sel`=0, `eq_level`=0, `rate_sel`=0 and `lane_cnt`=1.
- R2: In idle with `hpd` high, the next clock edge enters clock-recovery. It sets `pattern_sel`=1, `rate_sel`=`cap_rate` and `eq_level`=0. `lane_cnt` is `cap_lanes` rounded down to 4, 2 or 1, with 0 counting as 1.
- R3: A lane is active when its index is below `lane_cnt`, and lock bits of inactive lanes have no effect. When all active `cr_lock` bits are high at an edge in clock-recovery, the block enters the align phase with `pattern_sel`=2 and `eq_level`=0.
- R4: Each attempt in a phase that fails to lock raises `eq_level` by one (0 to 4). The fifth failed attempt ends the phase as a failure.
- R5: In the align phase, when all active lanes show both `cr_lock` and `eq_lock` at an edge, the block enters live with `link_up`=1 and `pattern_sel`=0.
- R6: A phase failure restarts clock-recovery with `eq_level`=0. If `rate_sel` was above 0 it drops by one and the lane count stays. At rate 0 with more than one lane, the lane count halves and the rate returns to the captured `cap_rate`.
- R7: A phase failure at one lane and rate 0 enters halt. There `train_err`=1, `pattern_sel`=0 and `link_up`=0, and the block stays there while `hpd` is high.
- R8: `link_up` is high only in live, never together with a training pattern or with `train_err`.
- R9: In live, if any active lane lacks `cr_lock` or `eq_lock` at an edge, `link_up` is low right after that edge. The block re-enters clock-recovery with the same `rate_sel` and `lane_cnt` and `eq_level`=0.
- R10: `hpd` low at an edge sends the block to idle from any state (`pattern_sel`=0, `link_up`=0, `train_err`=0). This takes priority over every other transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hpd | input | 1 | Hot-plug detect level |
| cap_rate | input | 2 | Sink's highest rate code |
| cap_lanes | input | 3 | Sink's lane count |
| cr_lock | input | 4 | Per-lane clock-recovery lock |
| eq_lock | input | 4 | Per-lane symbol/equalization lock |
| rate_sel | output | 2 | Selected rate code |
| lane_cnt | output | 3 | Selected lane count (1, 2, 4) |
| pattern_sel | output | 2 | 0 none, 1 clock-recovery pattern, 2 alignment pattern |
| eq_level | output | 3 | Transmitter equalization setting |
| link_up | output | 1 | Link ready; video may flow |
| train_err | output | 1 | Training exhausted |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a lock loss on a live link and the removal of hot-plug. The bench drops `hpd` and one lane's `eq_lock` on the same falling edge, and judges that the block lands in idle (`pattern_sel`=0) rather than clock-recovery (`pattern_sel`=1). The second pair is a lock arriving and the attempt limit being reached. The table cases where the sink locks only at a lower rate step through these limits. Each case is judged by the final rate, lane count and exact edge count to `link_up`, all computed in the bench from the ladder rules.

// File: rtl/lt_pkg.sv
package lt_pkg;
    typedef enum logic [2:0] {
        LT_IDLE,
        LT_CLKREC,
        LT_ALIGN,
        LT_LIVE,
        LT_HALT
    } lt_state_e;

    localparam int RATE_W = 2;
    localparam logic [1:0] PAT_NONE   = 2'd0;
    localparam logic [1:0] PAT_CLKREC = 2'd1;
    localparam logic [1:0] PAT_ALIGN  = 2'd2;
endpackage

// File: rtl/lt_lock_eval.sv
module lt_lock_eval #(
    parameter int MAX_LANES = 4,
    parameter int LCW       = 3
) (
    input  logic [LCW-1:0]       lane_cnt,
    input  logic [MAX_LANES-1:0] cr_lock,
    input  logic [MAX_LANES-1:0] eq_lock,
    output logic                 cr_all,
    output logic                 eq_all
);
    logic [MAX_LANES-1:0] active;

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        assign active[g] = (LCW'(g) < lane_cnt);
    end

    // inactive lanes are forced to "locked" so they never block progress
    assign cr_all = &(cr_lock | ~active);
    assign eq_all = &(eq_lock | ~active);
endmodule

// File: rtl/lt_ladder.sv
module lt_ladder #(
    parameter int RATE_W = 2,
    parameter int LCW    = 3
) (
    input  logic [RATE_W-1:0] rate,
    input  logic [RATE_W-1:0] top_rate,
    input  logic [LCW-1:0]    lanes,
    output logic [RATE_W-1:0] next_rate,
    output logic [LCW-1:0]    next_lanes,
    output logic              exhausted
);
    always_comb begin
        next_rate  = rate;
        next_lanes = lanes;
        exhausted  = 1'b0;
        if (rate != '0) begin
            next_rate = rate - RATE_W'(1);
        end else if (lanes > LCW'(1)) begin
            next_rate  = top_rate;
            next_lanes = lanes >> 1;
        end else begin
            exhausted = 1'b1;
        end
    end
endmodule

// File: rtl/lt_try_count.sv
module lt_try_count #(
    parameter int TRIES = 5,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + CW'(1);
        end
    end

    assign last = (count == CW'(TRIES - 1));
endmodule

// File: rtl/link_train_ctrl.sv
module link_train_ctrl
    import lt_pkg::*;
#(
    parameter int MAX_LANES = 4,
    parameter int EQ_TRIES  = 5,
    localparam int LOG_L    = $clog2(MAX_LANES),
    localparam int LCW      = LOG_L + 1,
    localparam int LVL_W    = (EQ_TRIES > 1) ? $clog2(EQ_TRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hpd,
    input  logic [RATE_W-1:0]    cap_rate,
    input  logic [LCW-1:0]       cap_lanes,
    input  logic [MAX_LANES-1:0] cr_lock,
    input  logic [MAX_LANES-1:0] eq_lock,
    output logic [RATE_W-1:0]    rate_sel,
    output logic [LCW-1:0]       lane_cnt,
    output logic [1:0]           pattern_sel,
    output logic [LVL_W-1:0]     eq_level,
    output logic                 link_up,
    output logic                 train_err
);
    lt_state_e          state, state_d;
    logic [RATE_W-1:0]  rate_q, top_q;
    logic [LCW-1:0]     lanes_q, cap_norm;
    logic               cnt_clear, cnt_step, ld_start, ld_fb;
    logic               cr_all, eq_all, last_try, exhausted;
    logic [RATE_W-1:0]  fb_rate;
    logic [LCW-1:0]     fb_lanes;
    logic [LVL_W-1:0]   try_cnt;

    lt_lock_eval #(.MAX_LANES(MAX_LANES), .LCW(LCW)) u_lock (
        .lane_cnt (lanes_q),
        .cr_lock  (cr_lock),
        .eq_lock  (eq_lock),
        .cr_all   (cr_all),
        .eq_all   (eq_all)
    );

    lt_ladder #(.RATE_W(RATE_W), .LCW(LCW)) u_ladder (
        .rate       (rate_q),
        .top_rate   (top_q),
        .lanes      (lanes_q),
        .next_rate  (fb_rate),
        .next_lanes (fb_lanes),
        .exhausted  (exhausted)
    );

    lt_try_count #(.TRIES(EQ_TRIES), .CW(LVL_W)) u_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .step  (cnt_step),
        .count (try_cnt),
        .last  (last_try)
    );

    // largest power of two not above the advertised count, capped by MAX_LANES
    always_comb begin
        cap_norm = LCW'(1);
        for (int k = 1; k <= LOG_L; k++) begin
            if (cap_lanes >= (LCW'(1) << k)) begin
                cap_norm = LCW'(1) << k;
            end
        end
    end

    // next-state and control decode
    always_comb begin
        state_d   = state;
        cnt_clear = 1'b0;
        cnt_step  = 1'b0;
        ld_start  = 1'b0;
        ld_fb     = 1'b0;
        if (!hpd) begin
            state_d   = LT_IDLE;
            cnt_clear = 1'b1;
        end else begin
            unique case (state)
                LT_IDLE: begin
                    state_d   = LT_CLKREC;
                    ld_start  = 1'b1;
                    cnt_clear = 1'b1;
                end
                LT_CLKREC: begin
                    if (cr_all) begin
                        state_d   = LT_ALIGN;
                        cnt_clear = 1'b1;
                    end else if (last_try) begin
                        cnt_clear = 1'b1;
                        if (exhausted) begin
                            state_d = LT_HALT;
                        end else begin
                            ld_fb = 1'b1;
                        end
                    end else begin
                        cnt_step = 1'b1;
                    end
                end
                LT_ALIGN: begin
                    if (cr_all && eq_all) begin
                        state_d   = LT_LIVE;
                        cnt_clear = 1'b1;
                    end else if (last_try) begin
                        cnt_clear = 1'b1;
                        if (exhausted) begin
                            state_d = LT_HALT;
                        end else begin
                            state_d = LT_CLKREC;
                            ld_fb   = 1'b1;
                        end
                    end else begin
                        cnt_step = 1'b1;
                    end
                end
                LT_LIVE: begin
                    if (!(cr_all && eq_all)) begin
                        state_d   = LT_CLKREC;
                        cnt_clear = 1'b1;
                    end
                end
                LT_HALT: begin
                    state_d = LT_HALT;
                end
                default: begin
                    state_d   = LT_IDLE;
                    cnt_clear = 1'b1;
                end
            endcase
        end
    end

    // state and setting registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= LT_IDLE;
            rate_q  <= '0;
            top_q   <= '0;
            lanes_q <= LCW'(1);
        end else begin
            state <= state_d;
            if (ld_start) begin
                rate_q  <= cap_rate;
                top_q   <= cap_rate;
                lanes_q <= cap_norm;
            end else if (ld_fb) begin
                rate_q  <= fb_rate;
                lanes_q <= fb_lanes;
            end
        end
    end

    // outputs from state
    always_comb begin
        rate_sel    = rate_q;
        lane_cnt    = lanes_q;
        pattern_sel = PAT_NONE;
        eq_level    = '0;
        link_up     = 1'b0;
        train_err   = 1'b0;
        unique case (state)
            LT_IDLE: ;
            LT_CLKREC: begin
                pattern_sel = PAT_CLKREC;
                eq_level    = try_cnt;
            end
            LT_ALIGN: begin
                pattern_sel = PAT_ALIGN;
                eq_level    = try_cnt;
            end
            LT_LIVE:  link_up   = 1'b1;
            LT_HALT:  train_err = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/lt_checker.sv
module lt_checker #(
    parameter int MAX_LANES = 4,
    parameter int EQ_TRIES  = 5,
    localparam int LCW      = $clog2(MAX_LANES) + 1,
    localparam int LVL_W    = (EQ_TRIES > 1) ? $clog2(EQ_TRIES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hpd,
    input logic [MAX_LANES-1:0] cr_lock,
    input logic [MAX_LANES-1:0] eq_lock,
    input logic [1:0]           rate_sel,
    input logic [LCW-1:0]       lane_cnt,
    input logic [1:0]           pattern_sel,
    input logic [LVL_W-1:0]     eq_level,
    input logic                 link_up,
    input logic                 train_err
);
    logic all_locked;
    always_comb begin
        all_locked = 1'b1;
        for (int k = 0; k < MAX_LANES; k++) begin
            if (LCW'(k) < lane_cnt && !(cr_lock[k] && eq_lock[k])) begin
                all_locked = 1'b0;
            end
        end
    end

    AST_START_CLKREC: assert property (@(posedge clk) disable iff (!rst_n)
        (hpd && pattern_sel == 2'd0 && !link_up && !train_err) |=> pattern_sel == 2'd1); // R2

    AST_EQ_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        eq_level <= LVL_W'(EQ_TRIES - 1)); // R4

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (train_err && hpd) |=> train_err); // R7

    AST_UP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> (pattern_sel == 2'd0 && !train_err)); // R8

    AST_LOSS_RETRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && hpd && !all_locked) |=> (!link_up && pattern_sel == 2'd1 && $stable(rate_sel) && $stable(lane_cnt))); // R9

    AST_UNPLUG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hpd |=> (!link_up && !train_err && pattern_sel == 2'd0)); // R10
endmodule

bind link_train_ctrl lt_checker #(.MAX_LANES(MAX_LANES), .EQ_TRIES(EQ_TRIES)) u_lt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .hpd         (hpd),
    .cr_lock     (cr_lock),
    .eq_lock     (eq_lock),
    .rate_sel    (rate_sel),
    .lane_cnt    (lane_cnt),
    .pattern_sel (pattern_sel),
    .eq_level    (eq_level),
    .link_up     (link_up),
    .train_err   (train_err)
);

// File: tb/test_link_train_ctrl.sv
module test_link_train_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hpd = 1'b0;
    logic [1:0] cap_rate = 2'd0;
    logic [2:0] cap_lanes = 3'd1;
    logic [3:0] cr_lock, eq_lock;
    logic [1:0] rate_sel;
    logic [2:0] lane_cnt;
    logic [1:0] pattern_sel;
    logic [2:0] eq_level;
    logic       link_up, train_err;

    // sink model: automatic from thresholds, or manual bit patterns
    logic       sink_auto = 1'b1;
    logic [1:0] cr_r = 2'd3, eq_r = 2'd3;
    logic [2:0] ok_l = 3'd4;
    logic [3:0] cr_man = 4'h0, eq_man = 4'h0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    always_comb begin
        if (sink_auto) begin
            cr_lock = (rate_sel <= cr_r && lane_cnt <= ok_l) ? 4'hF : 4'h0;
            eq_lock = (rate_sel <= eq_r && lane_cnt <= ok_l) ? 4'hF : 4'h0;
        end else begin
            cr_lock = cr_man;
            eq_lock = eq_man;
        end
    end

    link_train_ctrl i_link_train_ctrl (
        .clk(clk), .rst_n(rst_n), .hpd(hpd), .cap_rate(cap_rate), .cap_lanes(cap_lanes),
        .cr_lock(cr_lock), .eq_lock(eq_lock), .rate_sel(rate_sel), .lane_cnt(lane_cnt),
        .pattern_sel(pattern_sel), .eq_level(eq_level), .link_up(link_up), .train_err(train_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int norm_l(input int c);
        return (c >= 4) ? 4 : (c >= 2) ? 2 : 1;
    endfunction

    // {cap_rate, cap_lanes, cr_r, eq_r, ok_l}
    localparam logic [11:0] VEC [0:7] = '{
        {2'd3, 3'd4, 2'd3, 2'd3, 3'd4},
        {2'd3, 3'd4, 2'd1, 2'd1, 3'd4},
        {2'd2, 3'd4, 2'd3, 2'd0, 3'd4},
        {2'd3, 3'd4, 2'd3, 2'd3, 3'd2},
        {2'd1, 3'd3, 2'd0, 2'd0, 3'd1},
        {2'd3, 3'd4, 2'd3, 2'd3, 3'd0},
        {2'd0, 3'd1, 2'd3, 2'd3, 3'd4},
        {2'd3, 3'd7, 2'd3, 2'd3, 3'd4}
    };

    initial begin
        int timeout = 2000;
        while (timeout > 0) begin
            @(posedge clk);
            timeout--;
        end
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        check(link_up == 0 && train_err == 0 && pattern_sel == 0 && eq_level == 0, "R1 flags", {link_up, train_err, pattern_sel}, 0);
        check(rate_sel == 0 && lane_cnt == 1, "R1 settings", {rate_sel, lane_cnt}, 1);
        rst_n = 1'b1;
        tick();

        // table walk: R2 R3 R5 R6 R7
        foreach (VEC[i]) begin
            int cr_, er, ol, r, l, er_exp, cy, n;
            bit done;
            hpd = 1'b0; tick(); tick();
            cap_rate = VEC[i][11:10]; cap_lanes = VEC[i][9:7];
            cr_r = VEC[i][6:5]; eq_r = VEC[i][4:3]; ok_l = VEC[i][2:0];
            cr_ = cr_r; er = eq_r; ol = ok_l;
            r = cap_rate; l = norm_l(cap_lanes); cy = 1; er_exp = 0; done = 0;
            while (!done) begin
                if (r <= cr_ && l <= ol && r <= er) begin cy += 2; done = 1; end
                else begin
                    cy += (r <= cr_ && l <= ol) ? 6 : 5;
                    if (r > 0) r--;
                    else if (l > 1) begin l = l / 2; r = cap_rate; end
                    else begin er_exp = 1; done = 1; end
                end
            end
            hpd = 1'b1;
            tick();
            check(pattern_sel == 1 && eq_level == 0 && rate_sel == cap_rate && lane_cnt == norm_l(cap_lanes),
                  "R2 start", {pattern_sel, rate_sel, lane_cnt}, {2'd1, cap_rate, 3'(norm_l(cap_lanes))});
            n = 1;
            while (!link_up && !train_err && n < 200) begin tick(); n++; end
            check(train_err == er_exp, "R7 error outcome", train_err, er_exp);
            check(n == cy, "R6 edges to result", n, cy);
            if (!er_exp) begin
                check(rate_sel == r && lane_cnt == l && pattern_sel == 0, "R5 final settings", {rate_sel, lane_cnt}, {2'(r), 3'(l)});
            end else begin
                repeat (8) tick();
                check(train_err == 1 && link_up == 0 && pattern_sel == 0, "R7 halt holds", train_err, 1);
                hpd = 1'b0; tick();
                check(train_err == 0 && pattern_sel == 0, "R10 unplug from halt", train_err, 0);
            end
        end

        // R4 / R6 equalization stepping and fallback, manual sink
        hpd = 1'b0; sink_auto = 1'b0; cr_man = 4'h0; eq_man = 4'h0; tick();
        cap_rate = 2'd3; cap_lanes = 3'd4; hpd = 1'b1; tick();
        for (int k = 0; k < 5; k++) begin
            check(eq_level == k && rate_sel == 3, "R4 eq step", eq_level, k);
            tick();
        end
        check(rate_sel == 2 && lane_cnt == 4 && eq_level == 0 && pattern_sel == 1, "R6 rate drop", rate_sel, 2);
        // R10 unplug mid-training
        hpd = 1'b0; tick();
        check(pattern_sel == 0 && link_up == 0, "R10 unplug mid-train", pattern_sel, 0);

        // R3 inactive lanes ignored (one lane, upper bits low)
        cap_lanes = 3'd1; cr_man = 4'b0001; eq_man = 4'b0001; hpd = 1'b1; tick();
        tick();
        check(pattern_sel == 2 && eq_level == 0, "R3 cr pass one lane", pattern_sel, 2);
        tick();
        check(link_up == 1 && pattern_sel == 0, "R5 ready one lane", link_up, 1);
        check(link_up == 1 && train_err == 0, "R8 up exclusive", train_err, 0);

        // R9 lock loss: retrain at same settings
        hpd = 1'b0; tick();
        cap_lanes = 3'd4; cr_man = 4'hF; eq_man = 4'hF; hpd = 1'b1;
        tick(); tick(); tick();
        check(link_up == 1 && rate_sel == 3 && lane_cnt == 4, "R5 ready four lanes", link_up, 1);
        eq_man = 4'b1110; tick();
        check(link_up == 0 && pattern_sel == 1 && rate_sel == 3 && lane_cnt == 4 && eq_level == 0,
              "R9 relock same settings", {link_up, pattern_sel}, 1);
        eq_man = 4'hF; tick(); tick();
        check(link_up == 1, "R9 recovered", link_up, 1);

        // R10 with R9 on the same edge: unplug wins
        hpd = 1'b0; eq_man = 4'b0111; tick();
        check(pattern_sel == 0 && link_up == 0, "R10 priority over R9", pattern_sel, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule